// File: doc/BRIEF.md
# Breakpoint and Debug-Mode Entry Controller

This block sits beside a CPU core and decides when the core must stop normal execution and enter debug mode. It compares the address of each executed instruction against two program-address comparators and the address of each data access against two data-address comparators. It also accepts an immediate halt request from the debugger and a flag from the decoder marking a software breakpoint instruction. When any of these sources fires, the block records which comparators matched, saves the return PC and the processor status, and raises a debug flag in the status it presents to the core.

A mode bit, sampled at entry, chooses what the core runs next. With the bit clear, the core is held and each instruction the debugger writes is handed to the core once. With the bit set, the core is redirected to a fixed monitor vector in normal program memory and runs without waiting for the debugger. A debug-return input sends the core back to the saved PC and status. A live copy of the PC is always visible to the debugger and never stalls the core.

Top module: `brk_halt_ctl`

## Requirements
- R1: While reset is asserted, dbg_mode, fetch_hold, redir_valid, resume, issue_valid and all hit bits are 0.
- R2: A trigger in cycle t (halt_req high, or any breakpoint source below, while not in debug mode) sets dbg_mode from cycle t+1 and loads ret_pc with cpu_pc and ret_status with cpu_status as sampled in cycle t.
- R3: Program comparator i fires when its enable bit is 1, ex_valid is 1 and cpu_pc equals its address; it then sets hit bit i (bits 0 to NPC-1).
- R4: Data comparator j fires when its enable bit is 1, mem_valid is 1, mem_addr equals its address and its 2-bit select allows the access (select bit 0 allows reads, mem_we=0; select bit 1 allows writes, mem_we=1); it then sets hit bit NPC+j.
- R5: ex_valid together with ex_swbrk is a software breakpoint and triggers entry without setting any hit bit.
- R6: When several sources fire in the same cycle, every matching hit bit is set and exactly one entry occurs.
- R7: status_out equals cpu_status outside debug mode; in debug mode it equals ret_status with bit D_BIT forced to 1.
- R8: When entered with cfg_monitor=0, fetch_hold is 1 throughout debug mode, and each cycle with dinst_we high (and dret low) gives issue_valid=1 and issue_data=dinst_data in the next cycle only.
- R9: When entered with cfg_monitor=1, the cycle after entry has redir_valid=1 with redir_pc=MON_VEC, fetch_hold stays 0, and dinst_we is ignored (issue_valid stays 0).
- R10: dret in debug mode gives, one cycle later, dbg_mode=0, redir_valid=1, resume=1 and redir_pc equal to the saved ret_pc.
- R11: After a return, the first executed instruction is not stopped by a program comparator or a software breakpoint if its PC equals ret_pc; any later instruction at that PC is.
- R12: In debug mode new triggers are ignored: no hit bit is set and ret_pc and ret_status stay unchanged.
- R13: hit_clr bit i high clears hit bit i in the next cycle unless the same bit is set in that same cycle.
- R14: dbg_pc shows the cpu_pc of the previous cycle in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_monitor | input | 1 | 1 selects the monitor vector, 0 debugger-fed instructions |
| halt_req | input | 1 | Unconditional halt from the debugger |
| pc_cmp_en | input | NPC | Program comparator enables |
| pc_cmp_addr | input | NPC*AW | Program comparator addresses, comparator i at bits i*AW |
| da_cmp_en | input | NDA | Data comparator enables |
| da_cmp_sel | input | 2*NDA | Access select per data comparator (bit 0 read, bit 1 write) |
| da_cmp_addr | input | NDA*AW | Data comparator addresses |
| hit_clr | input | NPC+NDA | Per-bit clear of the hit status |
| cpu_pc | input | AW | Current program counter |
| cpu_status | input | SW | Current processor status |
| ex_valid | input | 1 | The instruction at cpu_pc executes this cycle |
| ex_swbrk | input | 1 | That instruction is a breakpoint instruction |
| mem_valid | input | 1 | A data access takes place |
| mem_we | input | 1 | The data access is a write |
| mem_addr | input | AW | Data access address |
| dinst_we | input | 1 | Debugger writes the debug instruction register |
| dinst_data | input | IW | Written instruction |
| dret | input | 1 | Return from debug mode |
| dbg_mode | output | 1 | Debug mode active |
| status_out | output | SW | Status presented to the core |
| ret_pc | output | AW | Saved return PC |
| ret_status | output | SW | Saved status |
| fetch_hold | output | 1 | Core waits for debugger instructions |
| redir_valid | output | 1 | Core must fetch from redir_pc |
| redir_pc | output | AW | Redirect target |
| resume | output | 1 | Core reloads ret_status with the redirect |
| issue_valid | output | 1 | One debug instruction for the core |
| issue_data | output | IW | Debug instruction |
| hits | output | NPC+NDA | Sticky comparator hit bits |
| dbg_pc | output | AW | Live PC for the debugger |

## Verification
Every result of this block appears exactly one clock after the inputs that cause it: entry, saved PC and status, hit bits, the redirect pulse, the issued instruction, the return and the live PC all come from one register stage, while status_out follows the current cpu_status combinationally outside debug mode. The bench applies inputs on the falling edge, advances its own model by the same single step, and compares every output at the next falling edge, so each check looks at the cycle its result is due. Directed sequences cover the return guard, simultaneous sources and the two debug-mode variants before a long seeded random run.

// File: rtl/brk_pkg.sv
package brk_pkg;

  // data comparator access selection: bit 0 reads, bit 1 writes
  typedef enum logic [1:0] {
    ACC_OFF = 2'b00,
    ACC_RD  = 2'b01,
    ACC_WR  = 2'b10,
    ACC_RW  = 2'b11
  } acc_sel_e;

  function automatic logic acc_allowed(input acc_sel_e sel, input logic is_wr);
    logic [1:0] s;
    s = sel;
    return is_wr ? s[1] : s[0];
  endfunction

endpackage

// File: rtl/brk_addr_match.sv
module brk_addr_match
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          en,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] ref_addr,
  input  logic          acc_valid,
  input  logic          acc_we,
  input  logic [AW-1:0] acc_addr,
  output logic          hit
);

  always_comb begin
    hit = en && acc_valid && (acc_addr == ref_addr) &&
          acc_allowed(acc_sel_e'(sel), acc_we);
  end

endmodule

// File: rtl/brk_dbg_seq.sv
module brk_dbg_seq #(
  parameter int            AW      = 32,
  parameter int            SW      = 16,
  parameter int            IW      = 32,
  parameter logic [AW-1:0] MON_VEC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          cfg_monitor,
  input  logic [AW-1:0] cur_pc,
  input  logic [SW-1:0] cur_status,
  input  logic          ex_valid,
  input  logic          dret,
  input  logic          dinst_we,
  input  logic [IW-1:0] dinst_data,
  output logic          dbg_mode,
  output logic          mon_mode,
  output logic          ret_guard,
  output logic [AW-1:0] ret_pc,
  output logic [SW-1:0] ret_status,
  output logic          redir_valid,
  output logic [AW-1:0] redir_pc,
  output logic          resume,
  output logic          issue_valid,
  output logic [IW-1:0] issue_data
);

  logic          mode_q, mode_d, mon_q, mon_d, guard_q, guard_d;
  logic [AW-1:0] rpc_q, rpc_d, tgt_q, tgt_d;
  logic [SW-1:0] rst_q, rst_d;
  logic          rv_q, rv_d, res_q, res_d, iv_q, iv_d;
  logic [IW-1:0] id_q, id_d;
  logic          enter, leave;

  assign enter = !mode_q && trig;
  assign leave = mode_q && dret;

  always_comb begin
    mode_d  = mode_q;
    mon_d   = mon_q;
    rpc_d   = rpc_q;
    rst_d   = rst_q;
    tgt_d   = tgt_q;
    id_d    = id_q;
    rv_d    = 1'b0;
    res_d   = 1'b0;
    iv_d    = 1'b0;
    guard_d = ex_valid ? 1'b0 : guard_q;
    if (enter) begin
      mode_d = 1'b1;
      mon_d  = cfg_monitor;
      rpc_d  = cur_pc;
      rst_d  = cur_status;
      if (cfg_monitor) begin
        rv_d  = 1'b1;
        tgt_d = MON_VEC;
      end
    end else if (leave) begin
      mode_d  = 1'b0;
      rv_d    = 1'b1;
      tgt_d   = rpc_q;
      res_d   = 1'b1;
      guard_d = 1'b1;
    end else if (mode_q && !mon_q && dinst_we) begin
      iv_d = 1'b1;
      id_d = dinst_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      mon_q   <= 1'b0;
      guard_q <= 1'b0;
      rpc_q   <= '0;
      rst_q   <= '0;
      tgt_q   <= '0;
      rv_q    <= 1'b0;
      res_q   <= 1'b0;
      iv_q    <= 1'b0;
      id_q    <= '0;
    end else begin
      mode_q  <= mode_d;
      mon_q   <= mon_d;
      guard_q <= guard_d;
      rpc_q   <= rpc_d;
      rst_q   <= rst_d;
      tgt_q   <= tgt_d;
      rv_q    <= rv_d;
      res_q   <= res_d;
      iv_q    <= iv_d;
      id_q    <= id_d;
    end
  end

  assign dbg_mode    = mode_q;
  assign mon_mode    = mon_q;
  assign ret_guard   = guard_q;
  assign ret_pc      = rpc_q;
  assign ret_status  = rst_q;
  assign redir_valid = rv_q;
  assign redir_pc    = tgt_q;
  assign resume      = res_q;
  assign issue_valid = iv_q;
  assign issue_data  = id_q;

  assert_entry_saves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !mode_q) |=> (mode_q && rpc_q == $past(cur_pc) && rst_q == $past(cur_status)));

  assert_monitor_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !mode_q && cfg_monitor) |=> (rv_q && tgt_q == MON_VEC && !iv_q));

  assert_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dret && mode_q) |=> (!mode_q && rv_q && res_q && tgt_q == $past(rpc_q)));

  assert_frozen_in_debug_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !dret) |=> (mode_q && $stable(rpc_q) && $stable(rst_q)));

  assert_issue_only_ocd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iv_q |-> (mode_q && !mon_q && !rv_q));

endmodule

// File: rtl/brk_halt_ctl.sv
module brk_halt_ctl #(
  parameter int            AW      = 32,
  parameter int            SW      = 16,
  parameter int            IW      = 32,
  parameter int            NPC     = 2,
  parameter int            NDA     = 2,
  parameter int            D_BIT   = 5,
  parameter logic [AW-1:0] MON_VEC = 32'h0000_0100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_monitor,
  input  logic                 halt_req,
  input  logic [NPC-1:0]       pc_cmp_en,
  input  logic [NPC*AW-1:0]    pc_cmp_addr,
  input  logic [NDA-1:0]       da_cmp_en,
  input  logic [2*NDA-1:0]     da_cmp_sel,
  input  logic [NDA*AW-1:0]    da_cmp_addr,
  input  logic [NPC+NDA-1:0]   hit_clr,
  input  logic [AW-1:0]        cpu_pc,
  input  logic [SW-1:0]        cpu_status,
  input  logic                 ex_valid,
  input  logic                 ex_swbrk,
  input  logic                 mem_valid,
  input  logic                 mem_we,
  input  logic [AW-1:0]        mem_addr,
  input  logic                 dinst_we,
  input  logic [IW-1:0]        dinst_data,
  input  logic                 dret,
  output logic                 dbg_mode,
  output logic [SW-1:0]        status_out,
  output logic [AW-1:0]        ret_pc,
  output logic [SW-1:0]        ret_status,
  output logic                 fetch_hold,
  output logic                 redir_valid,
  output logic [AW-1:0]        redir_pc,
  output logic                 resume,
  output logic                 issue_valid,
  output logic [IW-1:0]        issue_data,
  output logic [NPC+NDA-1:0]   hits,
  output logic [AW-1:0]        dbg_pc
);

  localparam int NHIT = NPC + NDA;

  logic [NPC-1:0]  pc_hit_raw, pc_hit;
  logic [NDA-1:0]  da_hit;
  logic            guard, mon_mode, ret_mask, sw_hit, trig;
  logic [NHIT-1:0] hits_q, hits_d, hit_set;
  logic [AW-1:0]   pc_live_q;

  for (genvar i = 0; i < NPC; i++) begin : g_pc_cmp
    brk_addr_match #(.AW(AW)) u_cmp (
      .en        (pc_cmp_en[i]),
      .sel       (2'b11),
      .ref_addr  (pc_cmp_addr[i*AW +: AW]),
      .acc_valid (ex_valid),
      .acc_we    (1'b0),
      .acc_addr  (cpu_pc),
      .hit       (pc_hit_raw[i])
    );
  end

  for (genvar j = 0; j < NDA; j++) begin : g_da_cmp
    brk_addr_match #(.AW(AW)) u_cmp (
      .en        (da_cmp_en[j]),
      .sel       (da_cmp_sel[2*j +: 2]),
      .ref_addr  (da_cmp_addr[j*AW +: AW]),
      .acc_valid (mem_valid),
      .acc_we    (mem_we),
      .acc_addr  (mem_addr),
      .hit       (da_hit[j])
    );
  end

  // first instruction back at the return address may not re-trigger
  always_comb begin
    ret_mask = guard && ex_valid && (cpu_pc == ret_pc);
    pc_hit   = ret_mask ? '0 : pc_hit_raw;
    sw_hit   = ex_valid && ex_swbrk && !ret_mask;
    trig     = !dbg_mode && (halt_req || (|pc_hit) || (|da_hit) || sw_hit);
    hit_set  = trig ? {da_hit, pc_hit} : '0;
    hits_d   = (hits_q & ~hit_clr) | hit_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits_q    <= '0;
      pc_live_q <= '0;
    end else begin
      hits_q    <= hits_d;
      pc_live_q <= cpu_pc;
    end
  end

  brk_dbg_seq #(.AW(AW), .SW(SW), .IW(IW), .MON_VEC(MON_VEC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig        (trig),
    .cfg_monitor (cfg_monitor),
    .cur_pc      (cpu_pc),
    .cur_status  (cpu_status),
    .ex_valid    (ex_valid),
    .dret        (dret),
    .dinst_we    (dinst_we),
    .dinst_data  (dinst_data),
    .dbg_mode    (dbg_mode),
    .mon_mode    (mon_mode),
    .ret_guard   (guard),
    .ret_pc      (ret_pc),
    .ret_status  (ret_status),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .resume      (resume),
    .issue_valid (issue_valid),
    .issue_data  (issue_data)
  );

  always_comb begin
    status_out = cpu_status;
    if (dbg_mode) begin
      status_out        = ret_status;
      status_out[D_BIT] = 1'b1;
    end
  end

  assign fetch_hold = dbg_mode && !mon_mode;
  assign hits       = hits_q;
  assign dbg_pc     = pc_live_q;

  assert_no_new_hits_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode |=> ((hits_q & ~$past(hits_q)) == '0));

  assert_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode |=> ((hits_q & $past(hit_clr)) == '0));

  assert_live_pc_R14: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dbg_pc == $past(cpu_pc)));

  assert_status_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode |-> status_out[D_BIT]);

endmodule

// File: tb/brk_halt_ctl_test.sv
`timescale 1ns/1ps
module brk_halt_ctl_test;

  localparam int AW = 32, SW = 16, IW = 32, NPC = 2, NDA = 2, NHIT = 4, D_BIT = 5;
  localparam logic [AW-1:0] MON_VEC = 32'h0000_0100;
  localparam logic [AW-1:0] PA0 = 32'h1000, PA1 = 32'h1010, DA0 = 32'h8000, DA1 = 32'h8004;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_monitor, halt_req, ex_valid, ex_swbrk, mem_valid, mem_we, dinst_we, dret;
  logic [NPC-1:0] pc_cmp_en;
  logic [NPC*AW-1:0] pc_cmp_addr;
  logic [NDA-1:0] da_cmp_en;
  logic [2*NDA-1:0] da_cmp_sel;
  logic [NDA*AW-1:0] da_cmp_addr;
  logic [NHIT-1:0] hit_clr;
  logic [AW-1:0] cpu_pc, mem_addr;
  logic [SW-1:0] cpu_status;
  logic [IW-1:0] dinst_data;

  logic dbg_mode, fetch_hold, redir_valid, resume, issue_valid;
  logic [SW-1:0] status_out, ret_status;
  logic [AW-1:0] ret_pc, redir_pc, dbg_pc;
  logic [IW-1:0] issue_data;
  logic [NHIT-1:0] hits;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  // model state
  logic m_mode, m_mon, m_guard, m_rv, m_res, m_iv;
  logic [AW-1:0] m_ret, m_rpc, m_dpc;
  logic [SW-1:0] m_rst;
  logic [IW-1:0] m_id;
  logic [NHIT-1:0] m_hits;

  always #2 clk = ~clk;

  brk_halt_ctl #(.AW(AW), .SW(SW), .IW(IW), .NPC(NPC), .NDA(NDA), .D_BIT(D_BIT),
                 .MON_VEC(MON_VEC)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_monitor(cfg_monitor), .halt_req(halt_req),
    .pc_cmp_en(pc_cmp_en), .pc_cmp_addr(pc_cmp_addr), .da_cmp_en(da_cmp_en),
    .da_cmp_sel(da_cmp_sel), .da_cmp_addr(da_cmp_addr), .hit_clr(hit_clr),
    .cpu_pc(cpu_pc), .cpu_status(cpu_status), .ex_valid(ex_valid), .ex_swbrk(ex_swbrk),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .dinst_we(dinst_we),
    .dinst_data(dinst_data), .dret(dret), .dbg_mode(dbg_mode), .status_out(status_out),
    .ret_pc(ret_pc), .ret_status(ret_status), .fetch_hold(fetch_hold),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .resume(resume),
    .issue_valid(issue_valid), .issue_data(issue_data), .hits(hits), .dbg_pc(dbg_pc)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] exp_status();
    logic [SW-1:0] s;
    s = m_mode ? m_rst : cpu_status;
    if (m_mode) s[D_BIT] = 1'b1;
    return s;
  endfunction

  task automatic check_all();
    chk("R2 dbg_mode", dbg_mode, m_mode);
    chk("R2 ret_pc", ret_pc, m_ret);
    chk("R2 ret_status", ret_status, m_rst);
    chk("R7 status_out", status_out, exp_status());
    chk("R8 fetch_hold", fetch_hold, m_mode && !m_mon);
    chk("R8 issue_valid", issue_valid, m_iv);
    if (m_iv) chk("R8 issue_data", issue_data, m_id);
    chk("R9 R10 redir_valid", redir_valid, m_rv);
    if (m_rv) chk("R9 R10 redir_pc", redir_pc, m_rpc);
    chk("R10 resume", resume, m_res);
    chk("R3 R4 R6 R12 R13 hits", hits, m_hits);
    chk("R14 dbg_pc", dbg_pc, m_dpc);
  endtask

  // one clock: advance the model from the applied inputs, then compare
  task automatic cyc();
    logic [NPC-1:0] ph;
    logic [NDA-1:0] dh;
    logic g, sw, t, leave;
    g = m_guard && ex_valid && (cpu_pc == m_ret);
    for (int i = 0; i < NPC; i++)
      ph[i] = pc_cmp_en[i] && ex_valid && (cpu_pc == pc_cmp_addr[i*AW +: AW]) && !g;
    for (int j = 0; j < NDA; j++)
      dh[j] = da_cmp_en[j] && mem_valid && (mem_addr == da_cmp_addr[j*AW +: AW]) &&
              (mem_we ? da_cmp_sel[2*j+1] : da_cmp_sel[2*j]);
    sw = ex_valid && ex_swbrk && !g;
    t = !m_mode && (halt_req || (|ph) || (|dh) || sw);
    leave = m_mode && dret;
    @(negedge clk);
    m_hits = (m_hits & ~hit_clr) | (t ? {dh, ph} : '0);
    m_dpc = cpu_pc;
    m_iv = 1'b0; m_rv = 1'b0; m_res = 1'b0;
    if (!leave && ex_valid) m_guard = 1'b0;
    if (t) begin
      m_mode = 1'b1; m_mon = cfg_monitor; m_ret = cpu_pc; m_rst = cpu_status;
      if (cfg_monitor) begin m_rv = 1'b1; m_rpc = MON_VEC; end
    end else if (leave) begin
      m_mode = 1'b0; m_rv = 1'b1; m_rpc = m_ret; m_res = 1'b1; m_guard = 1'b1;
    end else if (m_mode && !m_mon && dinst_we) begin
      m_iv = 1'b1; m_id = dinst_data;
    end
    check_all();
  endtask

  task automatic idle_inputs();
    halt_req = 0; ex_valid = 0; ex_swbrk = 0; mem_valid = 0; mem_we = 0;
    dinst_we = 0; dret = 0; hit_clr = '0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  initial begin
    #800000;
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] s;
    s = $urandom(32'd2024);
    rst_n = 0; cfg_monitor = 0; idle_inputs();
    cpu_pc = 32'h40; cpu_status = 16'h0003; mem_addr = '0; dinst_data = '0;
    pc_cmp_en = 2'b11; pc_cmp_addr = {PA1, PA0};
    da_cmp_en = 2'b11; da_cmp_sel = {2'b01, 2'b10}; da_cmp_addr = {DA1, DA0};
    m_mode = 0; m_mon = 0; m_guard = 0; m_rv = 0; m_res = 0; m_iv = 0;
    m_ret = '0; m_rpc = '0; m_dpc = '0; m_rst = '0; m_id = '0; m_hits = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 dbg_mode", dbg_mode, 0);
    chk("R1 hits", hits, 0);
    chk("R1 fetch_hold", fetch_hold, 0);
    chk("R1 redir_valid", redir_valid, 0);
    chk("R1 issue_valid", issue_valid, 0);
    chk("R1 resume", resume, 0);
    rst_n = 1;
    cyc();

    // R2 unconditional halt, OCD variant
    halt_req = 1; cpu_pc = 32'h2222; cpu_status = 16'h00c1; cyc(); halt_req = 0;
    chk("R2 entered", dbg_mode, 1);
    chk("R2 saved pc", ret_pc, 32'h2222);
    chk("R7 debug flag", status_out[D_BIT], 1);
    // R8 one instruction per write
    dinst_we = 1; dinst_data = 32'hdead_0001; cyc(); dinst_we = 0;
    chk("R8 issued", issue_valid, 1);
    chk("R8 issued data", issue_data, 32'hdead_0001);
    cyc();
    chk("R8 single issue", issue_valid, 0);
    // R12 triggers ignored in debug mode
    ex_valid = 1; cpu_pc = PA0; halt_req = 1; cyc(); ex_valid = 0; halt_req = 0;
    chk("R12 no hit", hits, 0);
    chk("R12 ret pc kept", ret_pc, 32'h2222);
    // R10 return
    dret = 1; cyc(); dret = 0;
    chk("R10 left", dbg_mode, 0);
    chk("R10 redirect", redir_pc, 32'h2222);
    chk("R10 resume", resume, 1);

    // R11 return guard and R3 program comparator
    halt_req = 1; cpu_pc = PA0; cyc(); halt_req = 0;
    dret = 1; cyc(); dret = 0;
    ex_valid = 1; cpu_pc = PA0; cyc();
    chk("R11 guarded", dbg_mode, 0);
    cyc(); ex_valid = 0;
    chk("R11 second time", dbg_mode, 1);
    chk("R3 hit bit 0", hits, 4'b0001);
    dret = 1; cyc(); dret = 0;
    hit_clr = 4'b0001; cyc(); hit_clr = '0;
    chk("R13 cleared", hits, 0);

    // R5 software breakpoint, R9 monitor variant
    ex_valid = 1; cpu_pc = 32'h3000; cyc();
    cfg_monitor = 1; ex_swbrk = 1; cpu_pc = 32'h3004; cyc(); ex_valid = 0; ex_swbrk = 0;
    chk("R5 sw entry", dbg_mode, 1);
    chk("R5 no hit bits", hits, 0);
    chk("R9 vector", redir_pc, MON_VEC);
    chk("R9 no hold", fetch_hold, 0);
    dinst_we = 1; cyc(); dinst_we = 0;
    chk("R9 write ignored", issue_valid, 0);
    dret = 1; cyc(); dret = 0; cfg_monitor = 0;

    // R4 select filtering, R6 simultaneous sources
    mem_valid = 1; mem_we = 0; mem_addr = DA0; cyc();
    chk("R4 read on write-only", dbg_mode, 0);
    ex_valid = 1; cpu_pc = PA1; mem_addr = DA1; cyc(); ex_valid = 0; mem_valid = 0;
    chk("R6 one entry", dbg_mode, 1);
    chk("R6 both hits", hits, 4'b1010);
    chk("R14 live pc", dbg_pc, PA1);
    dret = 1; cyc(); dret = 0;
    hit_clr = '1; cyc(); hit_clr = '0;

    // seeded random run
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 4));
      case (pick)
        0: cpu_pc = PA0;
        1: cpu_pc = PA1;
        2: cpu_pc = m_ret;
        default: cpu_pc = 32'h1000 + 32'($urandom_range(0, 7) * 4);
      endcase
      cpu_status = 16'($urandom);
      ex_valid = ($urandom_range(0, 1) == 0);
      ex_swbrk = ($urandom_range(0, 19) == 0);
      halt_req = ($urandom_range(0, 39) == 0);
      mem_valid = ($urandom_range(0, 3) == 0);
      mem_we = $urandom_range(0, 1) == 1;
      mem_addr = ($urandom_range(0, 1) == 0) ? DA0 : DA1;
      cfg_monitor = $urandom_range(0, 1) == 1;
      dinst_we = ($urandom_range(0, 2) == 0);
      dinst_data = $urandom;
      dret = ($urandom_range(0, 5) == 0);
      hit_clr = ($urandom_range(0, 7) == 0) ? 4'($urandom) : '0;
      if ((k % 500) == 0) da_cmp_sel = 4'($urandom);
      cyc();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule